// File: doc/BRIEF.md
# SDRAM Refresh Request Timer

This block decides when an SDRAM controller owes a refresh. A two-bit rate code from a control register selects the refresh spacing or turns refresh off. A static selector tells the block which of three memory clock frequencies is in use. From these two inputs the block looks up the interval length in clock cycles and counts it out. Each time an interval expires, one refresh is added to a pending count.

The memory sequencer sees the request line high whenever at least one refresh is pending. It acknowledges each refresh it performs with a single-cycle pulse, and each pulse removes one from the count. The count saturates, so a sequencer held off for a long time finds a bounded backlog when it returns. The block does not issue commands, program mode registers or track banks.

Top module: `sdram_refresh_timer`

## Requirements
- R1: While reset is asserted and right after it, `pending_count` is 0 and `refresh_req` is low.
- R2: The interval length N is found from the two inputs. For `rate_sel`, 01 is 7.8 us, 10 is 15.6 us and 11 is 125 us. For `clk_sel`, 00 is 66 MHz, 01 is 100 MHz, 10 is 133 MHz, and 11 is treated as 66 MHz. N is the interval in tenths of a microsecond, times the MHz figure, divided by 10 and rounded down. This gives 514/780/1037 for code 01, 1029/1560/2074 for code 10, and 8250/12500/16625 for code 11.
- R3: The first clock edge at which a new (`rate_sel`, `clk_sel`) pair is seen is edge 0. If the rate code is non-zero, an interval expires at edge N, and again every N edges after that.
- R4: With `rate_sel` = 00, no interval ever expires and `refresh_req` stays low.
- R5: An edge with `refresh_ack` high lowers a non-zero pending count by one. At a count of 0 the acknowledge is ignored.
- R6: An expiry and an acknowledge on the same edge leave a non-zero count unchanged, including a count of 8.
- R7: The pending count saturates at 8. An expiry with no acknowledge at 8 leaves it at 8.
- R8: `refresh_req` is high exactly when `pending_count` is non-zero.
- R9: Any change of `rate_sel` or `clk_sel` restarts the interval from zero. The pending count is kept, unless R10 applies.
- R10: The edge at which `rate_sel` becomes 00 clears the pending count, whether or not an acknowledge is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and is released in step with clk |
| rate_sel | input | 2 | Refresh rate code (00 = off) |
| clk_sel | input | 2 | Memory clock frequency selector |
| refresh_ack | input | 1 | One pulse per refresh performed by the sequencer |
| refresh_req | output | 1 | High while refreshes are owed |
| pending_count | output | 4 | Number of owed refreshes, 0 to 8 |

## Verification
The bench measures every rate and frequency pair to the exact edge. A wrong table entry or an off-by-one count would move the first expiry by a cycle. A second check targets saturation: an unbounded or wrapping counter would read 9 or 0 after nine unacknowledged intervals. The bench also drives an acknowledge on the same edge as an expiry. A design that gives one of the two events priority would drift the count by one. Finally, the bench changes the rate part-way through an interval. A design that kept the old count running would expire early, and a design that left pending refreshes in place when switched off would keep its request high.

// File: rtl/sdram_refresh_pkg.sv
package sdram_refresh_pkg;

  typedef enum logic [1:0] {
    RATE_OFF  = 2'b00,
    RATE_SHORT = 2'b01,
    RATE_MID  = 2'b10,
    RATE_LONG = 2'b11
  } rate_e;

  typedef enum logic [1:0] {
    CLK_66   = 2'b00,
    CLK_100  = 2'b01,
    CLK_133  = 2'b10,
    CLK_RSVD = 2'b11
  } clk_e;

  // interval length in tenths of a microsecond
  function automatic int unsigned rate_tenths_us(rate_e r);
    case (r)
      RATE_SHORT: return 78;
      RATE_MID:   return 156;
      RATE_LONG:  return 1250;
      default:    return 0;
    endcase
  endfunction

  // reserved frequency code falls back to the slowest clock (shortest count)
  function automatic int unsigned clk_mhz(clk_e f);
    case (f)
      CLK_100: return 100;
      CLK_133: return 133;
      default: return 66;
    endcase
  endfunction

  function automatic int unsigned interval_cycles(rate_e r, clk_e f);
    return (rate_tenths_us(r) * clk_mhz(f)) / 10;
  endfunction

  localparam int unsigned MAX_INTERVAL = (1250 * 133) / 10;

endpackage

// File: rtl/refresh_interval_lut.sv
module refresh_interval_lut
  import sdram_refresh_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  rate_e             rate,
  input  clk_e              fsel,
  output logic [CNT_W-1:0]  limit
);

  int unsigned cycles;

  always_comb begin
    cycles = interval_cycles(rate, fsel);
    if (cycles == 0) limit = '0;
    else             limit = CNT_W'(cycles - 1);
  end

endmodule

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             tick
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    tick  = 1'b0;
    cnt_d = cnt_q;
    if (restart) begin
      cnt_d = '0;
    end else if (run) begin
      if (cnt_q == limit) begin
        cnt_d = '0;
        tick  = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end else begin
      cnt_d = '0;
    end
    cnt_en = restart | run | (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart) |-> (cnt_q <= limit)); // R2
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0)); // R9
  AST_TICK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/refresh_pending_ctr.sv
module refresh_pending_ctr #(
  parameter int MAX_PENDING = 8,
  parameter int PEND_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ack,
  input  logic              clear,
  output logic [PEND_W-1:0] count
);

  localparam logic [PEND_W-1:0] CAP = PEND_W'(MAX_PENDING);

  logic [PEND_W-1:0] count_q, count_d;
  logic              dec, count_en;

  always_comb begin
    dec     = ack && (count_q != '0);
    count_d = count_q;
    if (clear)                        count_d = '0;
    else if (tick && dec)             count_d = count_q;
    else if (tick && count_q != CAP)  count_d = count_q + PEND_W'(1);
    else if (dec)                     count_d = count_q - PEND_W'(1);
    count_en = clear | tick | dec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  assign count = count_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CAP); // R7
  AST_ACK_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && count_q != '0 && !tick && !clear) |=> (count_q == $past(count_q) - PEND_W'(1))); // R5
  AST_TICK_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && tick && count_q != '0 && !clear) |=> $stable(count_q)); // R6
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count_q == '0)); // R10

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer
  import sdram_refresh_pkg::*;
#(
  parameter int MAX_PENDING = 8,
  parameter int PEND_W      = $clog2(MAX_PENDING + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        rate_sel,
  input  logic [1:0]        clk_sel,
  input  logic              refresh_ack,
  output logic              refresh_req,
  output logic [PEND_W-1:0] pending_count
);

  localparam int CNT_W = $clog2(MAX_INTERVAL);

  rate_e            rate_q;
  clk_e             fsel_q;
  logic             cfg_change, go_off, running, tick;
  logic [CNT_W-1:0] limit;

  always_comb begin
    cfg_change = (rate_sel != rate_q) || (clk_sel != fsel_q);
    go_off     = cfg_change && (rate_e'(rate_sel) == RATE_OFF);
    running    = (rate_q != RATE_OFF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= RATE_OFF;
      fsel_q <= CLK_66;
    end else if (cfg_change) begin
      rate_q <= rate_e'(rate_sel);
      fsel_q <= clk_e'(clk_sel);
    end
  end

  refresh_interval_lut #(.CNT_W(CNT_W)) u_lut (
    .rate  (rate_q),
    .fsel  (fsel_q),
    .limit (limit)
  );

  refresh_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (cfg_change),
    .run     (running),
    .limit   (limit),
    .tick    (tick)
  );

  refresh_pending_ctr #(.MAX_PENDING(MAX_PENDING), .PEND_W(PEND_W)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .ack   (refresh_ack),
    .clear (go_off),
    .count (pending_count)
  );

  assign refresh_req = (pending_count != '0);

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == 2'b00 && rate_q == RATE_OFF) |-> !refresh_req); // R4
  AST_REQ_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refresh_req) |-> $past(tick)); // R3

endmodule

// File: tb/sim_sdram_refresh_timer.sv
`timescale 1ns/1ps
module sim_sdram_refresh_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rate_sel = 2'b00;
  logic [1:0] clk_sel = 2'b00;
  logic       refresh_ack = 1'b0;
  logic       refresh_req;
  logic [3:0] pending_count;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  sdram_refresh_timer u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .rate_sel      (rate_sel),
    .clk_sel       (clk_sel),
    .refresh_ack   (refresh_ack),
    .refresh_req   (refresh_req),
    .pending_count (pending_count)
  );

  // R2 interval table, written from the requirement
  function automatic int exp_interval(logic [1:0] r, logic [1:0] f);
    int col;
    col = (f == 2'b01) ? 1 : (f == 2'b10) ? 2 : 0;
    case (r)
      2'b01:   return (col == 0) ? 514  : (col == 1) ? 780   : 1037;
      2'b10:   return (col == 0) ? 1029 : (col == 1) ? 1560  : 2074;
      2'b11:   return (col == 0) ? 8250 : (col == 1) ? 12500 : 16625;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // reference model of the requirements
  logic [1:0] m_rate, m_fsel;
  int         m_cnt, m_pend;
  bit         m_tick, m_clr, m_dec;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rate <= 2'b00; m_fsel <= 2'b00; m_cnt <= 0; m_pend <= 0;
    end else begin
      m_tick = 1'b0;
      m_clr  = 1'b0;
      if (rate_sel != m_rate || clk_sel != m_fsel) begin
        m_rate <= rate_sel;
        m_fsel <= clk_sel;
        m_cnt  <= 0;
        m_clr  = (rate_sel == 2'b00);
      end else if (m_rate != 2'b00) begin
        if (m_cnt == exp_interval(m_rate, m_fsel) - 1) begin
          m_tick = 1'b1;
          m_cnt  <= 0;
        end else begin
          m_cnt <= m_cnt + 1;
        end
      end
      m_dec = refresh_ack && (m_pend != 0);
      if (m_clr)                     m_pend <= 0;
      else if (m_tick && m_dec)      m_pend <= m_pend;
      else if (m_tick && m_pend < 8) m_pend <= m_pend + 1;
      else if (m_dec)                m_pend <= m_pend - 1;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 R5 R6 R7 pending", int'(pending_count), m_pend);
      chk("R8 request", int'(refresh_req), int'(m_pend != 0));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      fails++;
      $display("FAIL R1..: watchdog actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rate_sel = 2'b00; clk_sel = 2'b00; refresh_ack = 1'b0;
    @(negedge clk);
    chk("R1 count", int'(pending_count), 0);
    chk("R1 request", int'(refresh_req), 0);
    rst_n = 1'b1;
  endtask

  // first expiry lands exactly N edges after the edge that sees the new pair
  task automatic sweep(input logic [1:0] r, input logic [1:0] f);
    int n;
    do_reset();
    rate_sel = r; clk_sel = f;
    n = exp_interval(r, f);
    repeat (n) @(posedge clk);
    @(negedge clk);
    chk("R2 before expiry", int'(pending_count), 0);
    @(negedge clk);
    chk("R3 at expiry", int'(pending_count), 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    do_reset();

    for (int r = 1; r < 4; r++)
      for (int f = 0; f < 3; f++)
        sweep(2'(r), 2'(f));
    sweep(2'b01, 2'b11); // R2 reserved clock code

    // R7 saturation, then R5 draining and ack at zero
    do_reset();
    rate_sel = 2'b01; clk_sel = 2'b00;
    repeat (10 * 514 + 4) @(negedge clk);
    chk("R7 saturated", int'(pending_count), 8);
    chk("R8 request high", int'(refresh_req), 1);
    refresh_ack = 1'b1;
    repeat (8) @(negedge clk);
    refresh_ack = 1'b0;
    chk("R5 drained", int'(pending_count), 0);
    refresh_ack = 1'b1;
    @(negedge clk);
    refresh_ack = 1'b0;
    chk("R5 ack at zero", int'(pending_count), 0);

    // R6 expiry and ack on the same edge
    do_reset();
    rate_sel = 2'b01; clk_sel = 2'b00;
    repeat (515) @(negedge clk);
    chk("R6 setup", int'(pending_count), 1);
    repeat (513) @(negedge clk);
    refresh_ack = 1'b1;
    @(negedge clk);
    refresh_ack = 1'b0;
    chk("R6 tick with ack", int'(pending_count), 1);

    // R9 restart on rate change, count kept
    repeat (300) @(negedge clk);
    rate_sel = 2'b10;
    repeat (1029) @(negedge clk);
    chk("R9 no early expiry", int'(pending_count), 1);
    @(negedge clk);
    chk("R9 expiry after restart", int'(pending_count), 2);

    // R10 clear on switch-off even with ack, R4 stays quiet
    rate_sel = 2'b00; refresh_ack = 1'b1;
    @(negedge clk);
    refresh_ack = 1'b0;
    chk("R10 cleared", int'(pending_count), 0);
    chk("R10 request low", int'(refresh_req), 0);
    repeat (2000) @(negedge clk);
    chk("R4 off stays idle", int'(pending_count), 0);
    chk("R4 request low", int'(refresh_req), 0);

    // constrained random phase against the model
    rate_sel = 2'b01; clk_sel = 2'b00;
    for (int i = 0; i < 60000; i++) begin
      @(negedge clk);
      refresh_ack = (($urandom % 100) < 12);
      if (($urandom % 2500) == 0) rate_sel = 2'($urandom % 4);
      if (($urandom % 9000) == 0) clk_sel  = 2'($urandom % 4);
    end
    refresh_ack = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule